// File: doc/BRIEF.md
# Self-Refresh Exit Sequencer

This block takes a DDR2-style memory device out of low-power self refresh and brings it safely back into normal service. It leaves reset with the device assumed to be in self refresh and CKE low. When an exit request arrives, it waits for a clock-stable indication and only then drives CKE high. It holds the command bus at NOP and keeps ODT forced off until the non-read exit delay has run out. A second, longer delay gates read commands. Both delays are parameters counted in controller clocks.

Commands come from the command arbiter over a valid/ready interface. The arbiter presents `arb_cmd` with `arb_cmd_valid`, and a command is accepted in any cycle where both valid and `arb_cmd_ready` are high. The accepted command appears on `dram_cmd` in the same cycle. When no command is accepted, `dram_cmd` shows NOP. `arb_cmd_ready` depends only on the sequencer state and the command code, never on `arb_cmd_valid`, so the arbiter may hold a command and wait. After an exit, the block will not accept a self-refresh entry command until at least one refresh command has been accepted. It rejects any exit request that arrives while the device is out of self refresh and answers it with an error pulse.

Top module: `sr_exit_seq`

## Requirements
- R1: While reset is held and just after it, `dram_cke`, `arb_cmd_ready`, `dram_odt`, `nonread_ok`, `read_ok`, `sr_entry_ok` and `exit_err` are 0, and `dram_cmd` is NOP (code 0).
- R2: An exit request seen in self refresh starts a clock wait. `dram_cke` rises one cycle after the first clock edge in that wait at which `clk_stable` is high, and never earlier.
- R3: From reset until `nonread_ok` is high (self refresh, clock wait and exit interval), `arb_cmd_ready` is 0 and `dram_cmd` is NOP (code 0).
- R4: `dram_odt` is 0 whenever `nonread_ok` is 0. Otherwise it follows `arb_odt`.
- R5: `nonread_ok` rises exactly T_XSNR cycles after `dram_cke` rises, and `read_ok` rises exactly T_XSRD cycles after it. Both stay high until the next self-refresh entry.
- R6: Once `nonread_ok` is high, every command code other than READ (1) and SR_ENTER (6) is accepted: WRITE 2, ACTIVATE 3, PRECHARGE 4, REFRESH 5 and code 7. READ (1) is accepted only while `read_ok` is high.
- R7: `sr_entry_ok` goes high, and SR_ENTER (6) is accepted, only after `nonread_ok` is high and a REFRESH (5) has been accepted since the last exit.
- R8: An accepted SR_ENTER drives `dram_cke` low at the next edge and clears `nonread_ok`, `read_ok` and `sr_entry_ok`. In any other case `dram_cke` does not fall once it is high.
- R9: An exit request that arrives while `dram_cke` is high is ignored, and `exit_err` is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exit_req | input | 1 | Request to leave self refresh |
| clk_stable | input | 1 | Clock source reports a stable clock |
| arb_cmd_valid | input | 1 | Arbiter presents a command |
| arb_cmd | input | 3 | Command code (0 NOP, 1 READ, 2 WRITE, 3 ACTIVATE, 4 PRECHARGE, 5 REFRESH, 6 SR_ENTER, 7 other) |
| arb_odt | input | 1 | ODT value requested by the arbiter |
| arb_cmd_ready | output | 1 | Command would be accepted this cycle |
| dram_cmd | output | 3 | Command driven to the device |
| dram_cke | output | 1 | Clock enable to the device |
| dram_odt | output | 1 | ODT to the device |
| nonread_ok | output | 1 | Non-read exit delay has elapsed |
| read_ok | output | 1 | Read exit delay has elapsed |
| sr_entry_ok | output | 1 | Self-refresh re-entry is allowed |
| exit_err | output | 1 | One-cycle pulse for an exit request made out of self refresh |

## Verification
A directed exit holds `clk_stable` low for several cycles while reads are offered continuously. This shows whether CKE waits for the stable clock and whether reads stay blocked through the read window, which is longer than the non-read window. A second directed pass offers SR_ENTER before and after a REFRESH, and an exit request while active. These tell a missing refresh gate apart from a missing delay gate, and show whether the error pulse is raised. Random cycles with a fixed seed then mix exit requests, clock-stable gaps, arbiter stalls and all eight command codes over many exit and re-entry rounds. Each cycle is compared against a bench model, which catches off-by-one errors in either delay and any leak of a command or of ODT into the exit interval.

// File: rtl/sr_exit_pkg.sv
package sr_exit_pkg;
  typedef enum logic [2:0] {
    ST_IN_SR,
    ST_WAIT_CLK,
    ST_EXIT_NOP,
    ST_NEED_REF,
    ST_NORMAL
  } sr_state_e;

  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_NOP   = 3'd0;
  localparam logic [CMD_W-1:0] CMD_READ  = 3'd1;
  localparam logic [CMD_W-1:0] CMD_REF   = 3'd5;
  localparam logic [CMD_W-1:0] CMD_SRE   = 3'd6;
endpackage

// File: rtl/sr_exit_timer.sv
module sr_exit_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clr,
  input  logic [W-1:0] load_val,
  output logic         expire,
  output logic         done
);
  logic [W-1:0] cnt_q;

  // expire marks the edge at which the count reaches zero
  assign expire = (cnt_q == W'(1)) && !load && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      done  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
      if (cnt_q == W'(1)) done <= 1'b1;
    end
  end

  // R5: once set, the ready flag holds until cleared or reloaded
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr && !load) |=> done);
endmodule

// File: rtl/sr_exit_fsm.sv
module sr_exit_fsm
  import sr_exit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      exit_req,
  input  logic      clk_stable,
  input  logic      nr_expire,
  input  logic      acc_ref,
  input  logic      acc_sre,
  output sr_state_e state,
  output logic      cke,
  output logic      start,
  output logic      clr,
  output logic      exit_err
);
  sr_state_e state_d;
  logic      active;

  assign active = (state == ST_EXIT_NOP) || (state == ST_NEED_REF) || (state == ST_NORMAL);
  assign start  = (state == ST_WAIT_CLK) && clk_stable;
  assign clr    = (state == ST_NORMAL) && acc_sre;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IN_SR:    if (exit_req)  state_d = ST_WAIT_CLK;
      ST_WAIT_CLK: if (start)     state_d = ST_EXIT_NOP;
      ST_EXIT_NOP: if (nr_expire) state_d = ST_NEED_REF;
      ST_NEED_REF: if (acc_ref)   state_d = ST_NORMAL;
      ST_NORMAL:   if (acc_sre)   state_d = ST_IN_SR;
      default:                    state_d = ST_IN_SR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IN_SR;
      cke      <= 1'b0;
      exit_err <= 1'b0;
    end else begin
      state    <= state_d;
      exit_err <= exit_req && active;
      if (start)    cke <= 1'b1;
      else if (clr) cke <= 1'b0;
    end
  end

  // R2: CKE rises only after a stable clock was reported
  a_r2_cke_after_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable));
  // R8: CKE falls only on an accepted self-refresh entry
  a_r8_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(acc_sre));
  // R9: error pulse always traces back to an exit request
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    exit_err |-> $past(exit_req));
endmodule

// File: rtl/sr_exit_gate.sv
module sr_exit_gate
  import sr_exit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sr_state_e        state,
  input  logic             nr_ok,
  input  logic             rd_ok,
  input  logic             arb_cmd_valid,
  input  logic [CMD_W-1:0] arb_cmd,
  input  logic             arb_odt,
  output logic             arb_cmd_ready,
  output logic [CMD_W-1:0] dram_cmd,
  output logic             dram_odt,
  output logic             sr_entry_ok,
  output logic             acc_ref,
  output logic             acc_sre
);
  logic open_bus;
  logic accept;

  assign open_bus    = (state == ST_NEED_REF) || (state == ST_NORMAL);
  assign sr_entry_ok = (state == ST_NORMAL);

  always_comb begin
    if (!open_bus)                  arb_cmd_ready = 1'b0;
    else if (arb_cmd == CMD_READ)   arb_cmd_ready = rd_ok;
    else if (arb_cmd == CMD_SRE)    arb_cmd_ready = sr_entry_ok;
    else                            arb_cmd_ready = 1'b1;
  end

  assign accept   = arb_cmd_valid && arb_cmd_ready;
  assign dram_cmd = accept ? arb_cmd : CMD_NOP;
  assign dram_odt = arb_odt && open_bus;
  assign acc_ref  = accept && (arb_cmd == CMD_REF);
  assign acc_sre  = accept && (arb_cmd == CMD_SRE);

  // R3: bus carries only NOP until the non-read delay has elapsed
  a_r3_nop_in_exit: assert property (@(posedge clk) disable iff (!rst_n)
    !nr_ok |-> (dram_cmd == CMD_NOP));
  // R4: ODT is off until the non-read delay has elapsed
  a_r4_odt_off: assert property (@(posedge clk) disable iff (!rst_n)
    !nr_ok |-> !dram_odt);
  // R6: a read reaches the device only after the read delay
  a_r6_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cmd == CMD_READ) |-> rd_ok);
  // R7: re-entry permitted only after the non-read delay
  a_r7_entry_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    sr_entry_ok |-> nr_ok);
endmodule

// File: rtl/sr_exit_seq.sv
module sr_exit_seq
  import sr_exit_pkg::*;
#(
  parameter int T_XSNR = 12,
  parameter int T_XSRD = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exit_req,
  input  logic       clk_stable,
  input  logic       arb_cmd_valid,
  input  logic [2:0] arb_cmd,
  input  logic       arb_odt,
  output logic       arb_cmd_ready,
  output logic [2:0] dram_cmd,
  output logic       dram_cke,
  output logic       dram_odt,
  output logic       nonread_ok,
  output logic       read_ok,
  output logic       sr_entry_ok,
  output logic       exit_err
);
  localparam int T_MAX = (T_XSRD > T_XSNR) ? T_XSRD : T_XSNR;
  localparam int CW    = $clog2(T_MAX + 1);
  localparam int NT    = 2;

  sr_state_e     state;
  logic          start, clr, acc_ref, acc_sre;
  logic [NT-1:0] t_expire, t_done;
  logic [CW-1:0] t_len [NT];

  assign t_len[0] = CW'(T_XSNR);
  assign t_len[1] = CW'(T_XSRD);

  generate
    for (genvar i = 0; i < NT; i++) begin : g_timer
      sr_exit_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .clr      (clr),
        .load_val (t_len[i]),
        .expire   (t_expire[i]),
        .done     (t_done[i])
      );
    end
  endgenerate

  assign nonread_ok = t_done[0];
  assign read_ok    = t_done[1];

  sr_exit_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .exit_req   (exit_req),
    .clk_stable (clk_stable),
    .nr_expire  (t_expire[0]),
    .acc_ref    (acc_ref),
    .acc_sre    (acc_sre),
    .state      (state),
    .cke        (dram_cke),
    .start      (start),
    .clr        (clr),
    .exit_err   (exit_err)
  );

  sr_exit_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .nr_ok         (nonread_ok),
    .rd_ok         (read_ok),
    .arb_cmd_valid (arb_cmd_valid),
    .arb_cmd       (arb_cmd),
    .arb_odt       (arb_odt),
    .arb_cmd_ready (arb_cmd_ready),
    .dram_cmd      (dram_cmd),
    .dram_odt      (dram_odt),
    .sr_entry_ok   (sr_entry_ok),
    .acc_ref       (acc_ref),
    .acc_sre       (acc_sre)
  );

  // R5: read readiness never precedes non-read readiness
  a_r5_flag_order: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> nonread_ok);
endmodule

// File: tb/sr_exit_seq_test.sv
module sr_exit_seq_test;
  localparam int XSNR = 5;
  localparam int XSRD = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exit_req = 1'b0, clk_stable = 1'b0, arb_cmd_valid = 1'b0, arb_odt = 1'b0;
  logic [2:0] arb_cmd = 3'd0;
  logic       arb_cmd_ready, dram_cke, dram_odt, nonread_ok, read_ok, sr_entry_ok, exit_err;
  logic [2:0] dram_cmd;

  int n_chk = 0, n_bad = 0, cyc = 0;
  // model: 0 self refresh, 1 clock wait, 2 CKE high
  int m_st = 0, m_age = 0;
  bit m_ref = 0, m_err = 0;

  always #2 clk = ~clk;

  sr_exit_seq #(.T_XSNR(XSNR), .T_XSRD(XSRD)) uut (
    .clk(clk), .rst_n(rst_n), .exit_req(exit_req), .clk_stable(clk_stable),
    .arb_cmd_valid(arb_cmd_valid), .arb_cmd(arb_cmd), .arb_odt(arb_odt),
    .arb_cmd_ready(arb_cmd_ready), .dram_cmd(dram_cmd), .dram_cke(dram_cke),
    .dram_odt(dram_odt), .nonread_ok(nonread_ok), .read_ok(read_ok),
    .sr_entry_ok(sr_entry_ok), .exit_err(exit_err));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
    end
  endtask

  function automatic bit f_nr();  return m_st == 2 && m_age >= XSNR; endfunction
  function automatic bit f_rd();  return m_st == 2 && m_age >= XSRD; endfunction
  function automatic bit f_sre(); return f_nr() && m_ref; endfunction
  function automatic bit f_ready(input logic [2:0] c);
    if (!f_nr()) return 1'b0;
    if (c == 3'd1) return f_rd();
    if (c == 3'd6) return f_sre();
    return 1'b1;
  endfunction

  task automatic compare(input string pfx);
    bit rdy;
    rdy = f_ready(arb_cmd);
    chk({pfx, " R2/R8 cke"}, dram_cke, m_st == 2);
    chk({pfx, " R3/R6/R7 ready"}, arb_cmd_ready, rdy);
    chk({pfx, " R3 cmd"}, dram_cmd, (arb_cmd_valid && rdy) ? arb_cmd : 0);
    chk({pfx, " R4 odt"}, dram_odt, arb_odt && f_nr());
    chk({pfx, " R5 nonread_ok"}, nonread_ok, f_nr());
    chk({pfx, " R5 read_ok"}, read_ok, f_rd());
    chk({pfx, " R7 sr_entry_ok"}, sr_entry_ok, f_sre());
    chk({pfx, " R9 exit_err"}, exit_err, m_err);
  endtask

  task automatic advance_model();
    bit acc;
    acc   = arb_cmd_valid && f_ready(arb_cmd);
    m_err = exit_req && m_st == 2;
    case (m_st)
      0: if (exit_req) m_st = 1;
      1: if (clk_stable) begin m_st = 2; m_age = 0; end
      default: begin
        if (m_age < 1000) m_age++;
        if (acc && arb_cmd == 3'd5) m_ref = 1;
        if (acc && arb_cmd == 3'd6) begin m_st = 0; m_ref = 0; end
      end
    endcase
  endtask

  task automatic step(input bit e, input bit s, input bit v, input logic [2:0] c, input bit o);
    @(negedge clk);
    exit_req = e; clk_stable = s; arb_cmd_valid = v; arb_cmd = c; arb_odt = o;
    #1;
    compare("main");
    advance_model();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d (all requirements)", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    // R1: reset state
    repeat (3) begin
      @(negedge clk); #1;
      compare("R1 reset");
    end
    @(negedge clk); rst_n = 1'b1;
    #1; compare("R1 after reset");
    @(posedge clk);

    // R2: exit request, clock unstable for a while, reads offered throughout (R6)
    step(1, 0, 1, 3'd1, 1);
    repeat (6) step(0, 0, 1, 3'd1, 1);
    step(0, 1, 1, 3'd1, 1);
    repeat (XSRD + 2) step(0, 0, 1, 3'd1, 1);
    // R7: entry before any refresh is refused, R9: exit while active
    repeat (2) step(0, 0, 1, 3'd6, 0);
    step(1, 0, 1, 3'd2, 1);
    step(0, 0, 1, 3'd5, 0);
    step(0, 0, 1, 3'd6, 0);
    // R8: back in self refresh, exit with a stable clock at once
    step(1, 1, 1, 3'd5, 1);
    repeat (XSNR + 3) step(0, 1, 1, 3'd7, 1);

    // random mix of requests, clock gaps, stalls and all command codes
    for (int i = 0; i < 6000; i++) begin
      step(($urandom % 6) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
           3'($urandom % 8), ($urandom % 2) == 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule